// File: doc/BRIEF.md
# Servo Deviation-Clear Pulse Generator

This block drives the line that empties the position deviation counter inside an external servo amplifier. Without it, a motor keeps turning after command pulses stop, until that counter drains. Firing the line stops the motor at once. The block sits beside a pulse generator and its stop logic. It reads the upper bits of an environment word, the stop and completion strobes from its neighbours, and a command strobe with an 8-bit command code. From these it produces the clear output, a pulse-inhibit flag and a status bit for readback.

Bits 14:12 of the environment word select the output shape. Codes 000 to 110 give a one-shot of a fixed width. Those widths are converted to clock cycles from the `CLK_HZ` parameter and rounded to the nearest cycle. Code 111 gives a latched level that holds until the next start-of-motion strobe.

Bit 15 of the environment word sets the electrical polarity. Bits 11 and 10 arm automatic firing: bit 11 on zero-return completion, bit 10 on immediate stops. Bit 9 adds a recovery hold-off of `RECOVER_CYC` cycles after the output releases, and the inhibit flag stays set through it.

Top module: `servo_clr_gen`

## Requirements
- R1: Width codes 000..110 in bits 14:12 produce a one-shot lasting 12 µs, 102 µs, 408 µs, 1.6 ms, 13 ms, 52 ms and 104 ms respectively, each rounded to the nearest whole clock cycle (minimum one). The status bit rises in the cycle after the trigger and stays high for exactly that many cycles.
- R2: Bit 15 of the environment word sets polarity. With bit 15 = 1 the clear output is high while asserted and low while idle. With bit 15 = 0 it is low while asserted and high while idle.
- R3: A zero-return completion strobe fires the output only when bit 11 is 1.
- R4: With bit 10 = 1, the output fires on a stop strobe with cause 1 (end limit), 2 (alarm) or 3 (stop input), and on command code 05h (emergency stop). With bit 10 = 0, none of these fire it.
- R5: A stop strobe with cause 0 (deceleration stop) never fires the output, whatever bits 10 and 11 hold.
- R6: Command code 24h fires the output whatever bits 10 and 11 hold.
- R7: Code 111 asserts the output as a level. The level stays asserted until a start strobe arrives, and clears in the cycle after that strobe.
- R8: A trigger that arrives while a one-shot is active restarts the width count, so the output stays asserted for the full width measured from the retrigger.
- R9: The inhibit flag is high whenever the output is asserted. When bit 9 is 1 at release, the flag stays high for a further `RECOVER_CYC` cycles. When bit 9 is 0, it falls together with the output.
- R10: The status bit reports the logical asserted state, whatever the polarity bit holds.
- R11: Synchronous reset deasserts the output, the status bit, the recovery timer and the inhibit flag, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| env_cfg | input | 7 | Environment word bits 15:9 (polarity, width code, zero-return arm, stop arm, recovery enable) |
| zret_done | input | 1 | Strobe: zero-return operation finished |
| stop_valid | input | 1 | Strobe: the motion has stopped |
| stop_cause | input | 2 | Cause of the stop: 0 decel, 1 end limit, 2 alarm, 3 stop input |
| cmd_valid | input | 1 | Strobe: command written |
| cmd_code | input | 8 | Command code (24h clear output, 05h emergency stop) |
| start_cmd | input | 1 | Strobe: new motion start, releases level mode |
| clr_out | output | 1 | Clear output to the servo amplifier, polarity applied |
| pulse_inhibit | output | 1 | High while new command pulses must be held off |
| clr_status | output | 1 | Logical asserted state for readback |

## Verification
The bench measures every width code cycle by cycle. An off-by-one comparator or a wrong rounding would show up here as a pulse one cycle short or long. It drives a deceleration stop with both arm bits set; a decoder that treated any stop as a trigger would fire at that point. It retriggers in the middle of a pulse, where a design that ignores the second trigger ends 20 cycles early. It also times the inhibit flag against the recovery enable, and a design that dropped the hold-off, or applied it without the enable bit, would give the wrong length. Level mode is held for hundreds of cycles before release, and a reset is issued in the middle of a pulse. A design that timed out the level, or kept counting through reset, would be caught.

// File: rtl/servo_clr_gen.sv
`timescale 1ns/1ps
module servo_clr_gen #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned RECOVER_CYC = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:9] env_cfg,
  input  logic        zret_done,
  input  logic        stop_valid,
  input  logic [1:0]  stop_cause,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_code,
  input  logic        start_cmd,
  output logic        clr_out,
  output logic        pulse_inhibit,
  output logic        clr_status
);
  localparam logic [7:0] CMD_CLR   = 8'h24;
  localparam logic [7:0] CMD_ESTOP = 8'h05;
  localparam logic [1:0] CAUSE_DECEL = 2'd0;

  function automatic longint unsigned cyc_of(input logic [2:0] c);
    longint unsigned us, r;
    case (c)
      3'd0: us = 12;
      3'd1: us = 102;
      3'd2: us = 408;
      3'd3: us = 1600;
      3'd4: us = 13000;
      3'd5: us = 52000;
      default: us = 104000;
    endcase
    r = (us * longint'(CLK_HZ) + 500_000) / 1_000_000;
    return (r == 0) ? 1 : r;
  endfunction

  localparam longint unsigned MAXC = cyc_of(3'd6);
  localparam int CW = $clog2(MAXC + 1);
  localparam int RW = $clog2(RECOVER_CYC + 2);

  logic          active, lvl;
  logic [CW-1:0] cnt, tgt;
  logic [RW-1:0] rec;

  wire pol       = env_cfg[15];
  wire [2:0] wc  = env_cfg[14:12];
  wire arm_zret  = env_cfg[11];
  wire arm_stop  = env_cfg[10];
  wire etw_en    = env_cfg[9];

  wire manual    = cmd_valid && cmd_code == CMD_CLR;
  wire estop     = cmd_valid && cmd_code == CMD_ESTOP;
  wire hard_stop = stop_valid && stop_cause != CAUSE_DECEL;
  wire fire      = manual || (arm_zret && zret_done) || (arm_stop && (hard_stop || estop));
  wire done      = lvl ? start_cmd : (cnt == tgt - CW'(1));
  wire release_c = active && !fire && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      lvl    <= 1'b0;
      cnt    <= '0;
      tgt    <= '0;
      rec    <= '0;
    end else if (fire) begin
      active <= 1'b1;
      lvl    <= (wc == 3'd7);
      cnt    <= '0;
      tgt    <= CW'(cyc_of(wc));
      rec    <= '0;
    end else if (release_c) begin
      active <= 1'b0;
      cnt    <= '0;
      rec    <= etw_en ? RW'(RECOVER_CYC) : '0;
    end else begin
      if (active && !lvl) cnt <= cnt + CW'(1);
      if (rec != '0) rec <= rec - RW'(1);
    end
  end

  assign clr_status    = active;
  assign clr_out       = ~(active ^ pol);
  assign pulse_inhibit = active || (rec != '0);
endmodule

module servo_clr_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:9] env_cfg,
  input logic        zret_done,
  input logic        stop_valid,
  input logic [1:0]  stop_cause,
  input logic        cmd_valid,
  input logic [7:0]  cmd_code,
  input logic        start_cmd,
  input logic        clr_out,
  input logic        pulse_inhibit,
  input logic        clr_status
);
  a_r6_manual_fires: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_code == 8'h24 |=> clr_status);

  a_r5_decel_quiet: assert property (@(posedge clk) disable iff (rst)
    !clr_status && stop_valid && stop_cause == 2'd0 && !cmd_valid && !zret_done |=> !clr_status);

  a_r3_zret_unarmed: assert property (@(posedge clk) disable iff (rst)
    !clr_status && zret_done && !env_cfg[11] && !stop_valid && !cmd_valid |=> !clr_status);

  a_r4_stop_unarmed: assert property (@(posedge clk) disable iff (rst)
    !clr_status && stop_valid && !env_cfg[10] && !zret_done && !cmd_valid |=> !clr_status);

  a_r9_inhibit_covers: assert property (@(posedge clk) disable iff (rst)
    clr_status |-> pulse_inhibit);

  a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !clr_status && !pulse_inhibit);

  a_r10_status_vs_line: assert property (@(posedge clk) disable iff (rst)
    $stable(env_cfg[15]) && $rose(clr_status) |-> clr_out != $past(clr_out));
endmodule

bind servo_clr_gen servo_clr_gen_chk u_chk (
  .clk(clk), .rst(rst), .env_cfg(env_cfg), .zret_done(zret_done),
  .stop_valid(stop_valid), .stop_cause(stop_cause), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .start_cmd(start_cmd), .clr_out(clr_out),
  .pulse_inhibit(pulse_inhibit), .clr_status(clr_status)
);

// File: tb/servo_clr_gen_tb.sv
`timescale 1ns/1ps
module servo_clr_gen_tb;
  localparam int REC = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:9] env_cfg = '0;
  logic        zret_done = 1'b0, stop_valid = 1'b0, cmd_valid = 1'b0, start_cmd = 1'b0;
  logic [1:0]  stop_cause = '0;
  logic [7:0]  cmd_code = '0;
  logic        clr_out, pulse_inhibit, clr_status;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  servo_clr_gen #(.CLK_HZ(100_000), .RECOVER_CYC(REC)) u_dut (
    .clk(clk), .rst(rst), .env_cfg(env_cfg), .zret_done(zret_done),
    .stop_valid(stop_valid), .stop_cause(stop_cause), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .start_cmd(start_cmd), .clr_out(clr_out),
    .pulse_inhibit(pulse_inhibit), .clr_status(clr_status)
  );

  function automatic logic [15:9] mk(input logic pol, input logic [2:0] code,
                                     input logic zr, input logic imm, input logic etw);
    return {pol, code, zr, imm, etw};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 cmd 24h, 1 zero-return, 2 stop strobe with cause, 3 cmd 05h, 4 other cmd
  task automatic trig(input int kind, input logic [1:0] cause);
    case (kind)
      0: begin cmd_valid = 1'b1; cmd_code = 8'h24; end
      1: zret_done = 1'b1;
      2: begin stop_valid = 1'b1; stop_cause = cause; end
      3: begin cmd_valid = 1'b1; cmd_code = 8'h05; end
      default: begin cmd_valid = 1'b1; cmd_code = 8'h11; end
    endcase
    @(negedge clk);
    cmd_valid = 1'b0; zret_done = 1'b0; stop_valid = 1'b0; cmd_code = '0; stop_cause = '0;
  endtask

  task automatic measure(output int s, output int i);
    s = 0; i = 0;
    for (int k = 0; k < 20000; k++) begin
      if (clr_status) s++;
      if (pulse_inhibit) i++;
      if (!clr_status && !pulse_inhibit) break;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input string req, input int kind, input logic [1:0] cause);
    int hi = 0;
    trig(kind, cause);
    for (int k = 0; k < 4; k++) begin
      if (clr_status || pulse_inhibit) hi++;
      @(negedge clk);
    end
    check(req, hi, 0);
  endtask

  task automatic fires(input string req, input int kind, input logic [1:0] cause, input int w);
    int s, i;
    trig(kind, cause);
    measure(s, i);
    check(req, s, w);
  endtask

  task automatic t_reset;
    check("R11 reset status", clr_status, 0);
    check("R11 reset inhibit", pulse_inhibit, 0);
    check("R2 idle line pol0", clr_out, 1);
  endtask

  task automatic t_widths;
    int exp_w[7] = '{1, 10, 41, 160, 1300, 5200, 10400};
    int s, i;
    for (int c = 0; c < 7; c++) begin
      env_cfg = mk(1'b1, 3'(c), 1'b0, 1'b0, 1'b0);
      trig(0, 2'd0);
      measure(s, i);
      check($sformatf("R1 width code %0d", c), s, exp_w[c]);
      check($sformatf("R9 inhibit no etw code %0d", c), i, exp_w[c]);
    end
  endtask

  task automatic t_polarity;
    int s, i;
    env_cfg = mk(1'b1, 3'd1, 1'b0, 1'b0, 1'b0);
    check("R2 idle line pol1", clr_out, 0);
    trig(0, 2'd0);
    check("R2 active line pol1", clr_out, 1);
    check("R10 status pol1", clr_status, 1);
    measure(s, i);
    env_cfg = mk(1'b0, 3'd1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 idle line pol0", clr_out, 1);
    trig(0, 2'd0);
    check("R2 active line pol0", clr_out, 0);
    check("R10 status pol0", clr_status, 1);
    measure(s, i);
  endtask

  task automatic t_zret;
    env_cfg = mk(1'b1, 3'd1, 1'b0, 1'b1, 1'b0);
    quiet("R3 zero-return unarmed", 1, 2'd0);
    env_cfg = mk(1'b1, 3'd1, 1'b1, 1'b0, 1'b0);
    fires("R3 zero-return armed", 1, 2'd0, 10);
  endtask

  task automatic t_immediate;
    env_cfg = mk(1'b1, 3'd1, 1'b1, 1'b0, 1'b0);
    quiet("R4 limit unarmed", 2, 2'd1);
    quiet("R4 alarm unarmed", 2, 2'd2);
    quiet("R4 stop input unarmed", 2, 2'd3);
    quiet("R4 estop unarmed", 3, 2'd0);
    env_cfg = mk(1'b1, 3'd1, 1'b0, 1'b1, 1'b0);
    fires("R4 limit armed", 2, 2'd1, 10);
    fires("R4 alarm armed", 2, 2'd2, 10);
    fires("R4 stop input armed", 2, 2'd3, 10);
    fires("R4 estop armed", 3, 2'd0, 10);
    quiet("R4 unrelated cmd", 4, 2'd0);
  endtask

  task automatic t_decel;
    env_cfg = mk(1'b1, 3'd1, 1'b1, 1'b1, 1'b1);
    quiet("R5 decel stop", 2, 2'd0);
  endtask

  task automatic t_manual;
    env_cfg = mk(1'b1, 3'd2, 1'b0, 1'b0, 1'b0);
    fires("R6 manual cmd", 0, 2'd0, 41);
  endtask

  task automatic t_level;
    int hi = 0, s, i;
    env_cfg = mk(1'b1, 3'd7, 1'b0, 1'b0, 1'b0);
    trig(0, 2'd0);
    for (int k = 0; k < 300; k++) begin
      if (clr_status) hi++;
      @(negedge clk);
    end
    check("R7 level held", hi, 300);
    start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
    check("R7 level released", clr_status, 0);
    check("R9 level inhibit no etw", pulse_inhibit, 0);
    env_cfg = mk(1'b1, 3'd7, 1'b0, 1'b0, 1'b1);
    trig(0, 2'd0);
    repeat (10) @(negedge clk);
    start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
    check("R7 level released etw", clr_status, 0);
    measure(s, i);
    check("R9 level recovery", i, REC);
  endtask

  task automatic t_retrigger;
    int s, i;
    env_cfg = mk(1'b1, 3'd2, 1'b0, 1'b0, 1'b0);
    trig(0, 2'd0);
    repeat (19) @(negedge clk);
    check("R8 still active before retrigger", clr_status, 1);
    trig(0, 2'd0);
    measure(s, i);
    check("R8 width after retrigger", s, 41);
  endtask

  task automatic t_offtimer;
    int s, i;
    env_cfg = mk(1'b1, 3'd1, 1'b0, 1'b0, 1'b1);
    trig(0, 2'd0);
    measure(s, i);
    check("R9 etw pulse width", s, 10);
    check("R9 etw inhibit length", i, 10 + REC);
  endtask

  task automatic t_reset_mid;
    int hi = 0;
    env_cfg = mk(1'b1, 3'd4, 1'b0, 1'b0, 1'b1);
    trig(0, 2'd0);
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 mid-pulse reset status", clr_status, 0);
    check("R11 mid-pulse reset inhibit", pulse_inhibit, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (clr_status || pulse_inhibit) hi++;
    end
    check("R11 stays idle after reset", hi, 0);
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_widths();
    t_polarity();
    t_zret();
    t_immediate();
    t_decel();
    t_manual();
    t_level();
    t_retrigger();
    t_offtimer();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule